// File: doc/BRIEF.md
# Calendar Timekeeping Counters

This block keeps wall-clock time and the calendar date in hardware. A one-second event is built from either an enable pulse at an external 32.768 kHz rate (synchronised into the bus clock domain by the caller) or a programmable divider running on the bus clock. The divider has an integer reload and a fractional accumulator, so an exact average rate can be reached from a bus clock that is not a whole multiple of the sub-second rate. Both sources feed a sub-second counter of `SUB_W` bits, and each full wrap of that counter is one second.

From the second event the block advances seconds, minutes, hours, day of month, month and year. Day of week and day of year advance in parallel with the date. Every field is loaded through a simple write port and read back through a combinational read port. Any set of fields can be picked to raise an interrupt when they advance. Any set of binary fractions of a second can also be picked as periodic interrupt sources. Both sources set sticky status bits that are cleared by writing ones.

Top module: `rtc_calendar`

## Requirements
- R1: The register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year, 8 control, 9 prescaler, 10 increment mask, 11 fraction mask and 12 status. Unused addresses read as zero. After reset the fields read 2000-01-01 00:00:00, with day of week 6 and day of year 1. Control, masks and status read 0, and `irq` is low.
- R2: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap advances the next larger field by one.
- R3: Months 4, 6, 9 and 11 have 30 days and all other months except month 2 have 31. Month 2 has 29 days when the year is divisible by 4 and 28 days otherwise. After the last day, the day of month returns to 1.
- R4: After day 31 of month 12, the month becomes 1, the year advances by one and the day of year returns to 1.
- R5: Day of week advances with each new day and wraps from 6 to 0.
- R6: Day of year advances with each new day and reaches 366 on the last day of a leap year.
- R7: Control bit 0 enables counting. Control bit 1 selects the source: 1 means oscillator pulses and 0 means the prescaler. In oscillator mode, each `oscTickEn` cycle advances the sub-second count, and 2^SUB_W such cycles make one second.
- R8: The prescaler register holds the integer reload in bits [PINT_W-1:0] and the fraction in the next PFRAC_W bits. Each sub-second tick period lasts reload+1 clocks, plus one extra clock whenever adding the fraction into the accumulator carries out. With reload 2 and SUB_W 4, a second lasts 48 clocks at fraction 0 and 56 clocks at fraction one half (0x8000).
- R9: While control bit 0 is 0, no field changes except by writes, and writing fields sets no status bit.
- R10: Increment mask bit i (field order as in the addresses 0..7) sets status bit 0 on any second in which field i advances.
- R11: Fraction mask bit j sets status bit 1 on each sub-second tick that brings the sub-second count to a multiple of 2^(j+1).
- R12: Writing a 1 to a status bit clears it, writing 0 leaves it, and `irq` is high exactly when a status bit is set. A set event in the same cycle as the clear wins.
- R13: Clearing control bit 0 resets the sub-second phase and the prescaler, so counting restarts with a full second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTickEn | input | 1 | One-cycle pulse at the oscillator rate, synchronous to clk |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Register writes, field advances and status updates all land on the clock edge that samples the write or the final sub-second tick. Read data is combinational from the registers, so every result can be read in the same cycle that follows that edge. The bench drives inputs on the falling edge and reads on a later falling edge, which keeps every check clear of the updating edge. It uses whole counts of oscillator pulses so that the number of elapsed seconds is known exactly. For the prescaler, the bench measures the clock count between successive changes of the seconds field, after aligning to the first change.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int VAL_W      = 12;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 32;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_MDAY = 3;
  localparam int IDX_WDAY = 4;
  localparam int IDX_YDAY = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YEAR = 7;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_PRESC    = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_INCMASK  = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_FRACMASK = 4'd11;
  localparam logic [ADDR_W-1:0] ADDR_STAT     = 4'd12;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldWr;
    logic [VAL_W-1:0]      wrVal;
  } calStrobe_t;

  typedef struct packed {
    logic [5:0]  sec;
    logic [5:0]  min;
    logic [4:0]  hour;
    logic [4:0]  mday;
    logic [2:0]  wday;
    logic [8:0]  yday;
    logic [3:0]  mon;
    logic [11:0] year;
  } calTime_t;

  function automatic logic [4:0] daysInMonth(input logic [3:0] mon, input logic [11:0] year);
    logic [4:0] len;
    case (mon)
      4'd2:                      len = (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  len = 5'd30;
      default:                   len = 5'd31;
    endcase
    return len;
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int SUB_W   = 15,
  parameter int PINT_W  = 16,
  parameter int PFRAC_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               srcOsc,
  input  logic               oscTickEn,
  input  logic [PINT_W-1:0]  preInt,
  input  logic [PFRAC_W-1:0] preFrac,
  input  logic [SUB_W-2:0]   fracMask,
  output logic               secTick,
  output logic               fracHit
);
  localparam int FRAC_W = SUB_W - 1;

  logic [PINT_W-1:0]  cntQ;
  logic [PFRAC_W-1:0] accQ;
  logic [SUB_W-1:0]   subQ;
  logic [SUB_W-1:0]   subNext;
  logic [PFRAC_W:0]   accSum;
  logic               preTick;
  logic               subTick;
  logic [FRAC_W-1:0]  fracBits;

  assign preTick = run && !srcOsc && (cntQ == '0);
  assign subTick = run && (srcOsc ? oscTickEn : preTick);
  assign accSum  = {1'b0, accQ} + {1'b0, preFrac};
  assign subNext = subQ + 1'b1;

  // prescaler: integer reload stretched by one clock on fraction carry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      accQ <= '0;
    end else if (!run || srcOsc) begin
      cntQ <= preInt;
      accQ <= '0;
    end else if (preTick) begin
      cntQ <= preInt + PINT_W'(accSum[PFRAC_W]);
      accQ <= accSum[PFRAC_W-1:0];
    end else begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        subQ <= '0;
    else if (!run)    subQ <= '0;
    else if (subTick) subQ <= subNext;
  end

  assign secTick = subTick && (subQ == '1);

  for (genvar j = 0; j < FRAC_W; j++) begin : gFrac
    assign fracBits[j] = fracMask[j] && (subNext[j:0] == '0);
  end

  assign fracHit = subTick && (|fracBits);

  // R13
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !secTick);

  // R7
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcOsc && !oscTickEn) |-> !secTick);
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  calStrobe_t            strobe,
  output calTime_t              curTime,
  output logic [NUM_FIELDS-1:0] incFlags
);
  calTime_t   timeQ;
  calTime_t   timeNext;
  logic [4:0] monthLast;
  logic       secWrap, minWrap, hourWrap, dayWrap, monWrap;
  logic       minInc, hourInc, dayInc, monInc, yearInc;

  always_comb begin
    monthLast = daysInMonth(timeQ.mon, timeQ.year);
    secWrap   = timeQ.sec  >= 6'd59;
    minWrap   = timeQ.min  >= 6'd59;
    hourWrap  = timeQ.hour >= 5'd23;
    dayWrap   = timeQ.mday >= monthLast;
    monWrap   = timeQ.mon  >= 4'd12;
    minInc    = secTick && secWrap;
    hourInc   = minInc  && minWrap;
    dayInc    = hourInc && hourWrap;
    monInc    = dayInc  && dayWrap;
    yearInc   = monInc  && monWrap;
  end

  always_comb begin
    incFlags           = '0;
    incFlags[IDX_SEC]  = secTick;
    incFlags[IDX_MIN]  = minInc;
    incFlags[IDX_HOUR] = hourInc;
    incFlags[IDX_MDAY] = dayInc;
    incFlags[IDX_WDAY] = dayInc;
    incFlags[IDX_YDAY] = dayInc;
    incFlags[IDX_MON]  = monInc;
    incFlags[IDX_YEAR] = yearInc;
  end

  always_comb begin
    timeNext = timeQ;
    if (secTick) timeNext.sec  = secWrap  ? 6'd0 : timeQ.sec  + 6'd1;
    if (minInc)  timeNext.min  = minWrap  ? 6'd0 : timeQ.min  + 6'd1;
    if (hourInc) timeNext.hour = hourWrap ? 5'd0 : timeQ.hour + 5'd1;
    if (dayInc) begin
      timeNext.mday = dayWrap ? 5'd1 : timeQ.mday + 5'd1;
      timeNext.wday = (timeQ.wday >= 3'd6) ? 3'd0 : timeQ.wday + 3'd1;
      timeNext.yday = yearInc ? 9'd1 : timeQ.yday + 9'd1;
    end
    if (monInc)  timeNext.mon  = monWrap ? 4'd1 : timeQ.mon + 4'd1;
    if (yearInc) timeNext.year = timeQ.year + 12'd1;
    // a field write in the same cycle overrides that field only
    if (strobe.fieldWr[IDX_SEC])  timeNext.sec  = strobe.wrVal[5:0];
    if (strobe.fieldWr[IDX_MIN])  timeNext.min  = strobe.wrVal[5:0];
    if (strobe.fieldWr[IDX_HOUR]) timeNext.hour = strobe.wrVal[4:0];
    if (strobe.fieldWr[IDX_MDAY]) timeNext.mday = strobe.wrVal[4:0];
    if (strobe.fieldWr[IDX_WDAY]) timeNext.wday = strobe.wrVal[2:0];
    if (strobe.fieldWr[IDX_YDAY]) timeNext.yday = strobe.wrVal[8:0];
    if (strobe.fieldWr[IDX_MON])  timeNext.mon  = strobe.wrVal[3:0];
    if (strobe.fieldWr[IDX_YEAR]) timeNext.year = strobe.wrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ.sec  <= 6'd0;
      timeQ.min  <= 6'd0;
      timeQ.hour <= 5'd0;
      timeQ.mday <= 5'd1;
      timeQ.wday <= 3'd6;
      timeQ.yday <= 9'd1;
      timeQ.mon  <= 4'd1;
      timeQ.year <= 12'd2000;
    end else begin
      timeQ <= timeNext;
    end
  end

  assign curTime = timeQ;

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && timeQ.sec == 6'd59 && !strobe.fieldWr[IDX_SEC]) |=> (timeQ.sec == 6'd0));

  // R5
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incFlags[IDX_WDAY] && timeQ.wday == 3'd6 && !strobe.fieldWr[IDX_WDAY]) |=> (timeQ.wday == 3'd0));

  // R4
  yday_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incFlags[IDX_YEAR] && !strobe.fieldWr[IDX_YDAY]) |=> (timeQ.yday == 9'd1));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && strobe.fieldWr == '0) |=> $stable(timeQ));
endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int SUB_W   = 15,
  parameter int PINT_W  = 16,
  parameter int PFRAC_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  calTime_t              curTime,
  input  logic [NUM_FIELDS-1:0] incFlags,
  input  logic                  fracHit,
  output calStrobe_t            strobe,
  output logic                  run,
  output logic                  srcOsc,
  output logic [PINT_W-1:0]     preInt,
  output logic [PFRAC_W-1:0]    preFrac,
  output logic [SUB_W-2:0]      fracMask,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irq
);
  localparam int FRAC_W = SUB_W - 1;

  logic [1:0]            ctrlQ;
  logic [PINT_W-1:0]     preIntQ;
  logic [PFRAC_W-1:0]    preFracQ;
  logic [NUM_FIELDS-1:0] incMaskQ;
  logic [FRAC_W-1:0]     fracMaskQ;
  logic [1:0]            statQ;
  logic [1:0]            statNext;
  logic [1:0]            clrBits;
  logic                  incHit;

  always_comb begin
    strobe.wrVal = wrData[VAL_W-1:0];
    for (int i = 0; i < NUM_FIELDS; i++) begin
      strobe.fieldWr[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
  end

  assign incHit  = |(incFlags & incMaskQ);
  assign clrBits = (wrEn && wrAddr == ADDR_STAT) ? wrData[1:0] : 2'b00;

  always_comb begin
    statNext[0] = (statQ[0] & ~clrBits[0]) | incHit;
    statNext[1] = (statQ[1] & ~clrBits[1]) | fracHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      preIntQ   <= '0;
      preFracQ  <= '0;
      incMaskQ  <= '0;
      fracMaskQ <= '0;
      statQ     <= '0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          ADDR_CTRL:     ctrlQ     <= wrData[1:0];
          ADDR_PRESC: begin
            preIntQ  <= wrData[PINT_W-1:0];
            preFracQ <= wrData[PINT_W +: PFRAC_W];
          end
          ADDR_INCMASK:  incMaskQ  <= wrData[NUM_FIELDS-1:0];
          ADDR_FRACMASK: fracMaskQ <= wrData[FRAC_W-1:0];
          default: ;
        endcase
      end
      statQ <= statNext;
    end
  end

  assign run      = ctrlQ[0];
  assign srcOsc   = ctrlQ[1];
  assign preInt   = preIntQ;
  assign preFrac  = preFracQ;
  assign fracMask = fracMaskQ;
  assign irq      = |statQ;

  always_comb begin
    case (rdAddr)
      4'd0:          rdData = DATA_W'(curTime.sec);
      4'd1:          rdData = DATA_W'(curTime.min);
      4'd2:          rdData = DATA_W'(curTime.hour);
      4'd3:          rdData = DATA_W'(curTime.mday);
      4'd4:          rdData = DATA_W'(curTime.wday);
      4'd5:          rdData = DATA_W'(curTime.yday);
      4'd6:          rdData = DATA_W'(curTime.mon);
      4'd7:          rdData = DATA_W'(curTime.year);
      ADDR_CTRL:     rdData = DATA_W'(ctrlQ);
      ADDR_PRESC:    rdData = DATA_W'({preFracQ, preIntQ});
      ADDR_INCMASK:  rdData = DATA_W'(incMaskQ);
      ADDR_FRACMASK: rdData = DATA_W'(fracMaskQ);
      ADDR_STAT:     rdData = DATA_W'(statQ);
      default:       rdData = '0;
    endcase
  end

  // R10
  inc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    incHit |=> statQ[0]);

  // R11
  frac_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fracHit |=> statQ[1]);

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_STAT && wrData[0] && !incHit) |=> !statQ[0]);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int SUB_W   = 15,
  parameter int PINT_W  = 16,
  parameter int PFRAC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int FRAC_W = SUB_W - 1;

  calStrobe_t            strobe;
  calTime_t              curTime;
  logic [NUM_FIELDS-1:0] incFlags;
  logic                  run, srcOsc, secTick, fracHit;
  logic [PINT_W-1:0]     preInt;
  logic [PFRAC_W-1:0]    preFrac;
  logic [FRAC_W-1:0]     fracMask;

  rtc_cal_ctrl #(.SUB_W(SUB_W), .PINT_W(PINT_W), .PFRAC_W(PFRAC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .curTime(curTime), .incFlags(incFlags), .fracHit(fracHit),
    .strobe(strobe), .run(run), .srcOsc(srcOsc), .preInt(preInt), .preFrac(preFrac),
    .fracMask(fracMask), .rdData(rdData), .irq(irq)
  );

  rtc_tick_gen #(.SUB_W(SUB_W), .PINT_W(PINT_W), .PFRAC_W(PFRAC_W)) uTick (
    .clk(clk), .rstN(rstN), .run(run), .srcOsc(srcOsc), .oscTickEn(oscTickEn),
    .preInt(preInt), .preFrac(preFrac), .fracMask(fracMask),
    .secTick(secTick), .fracHit(fracHit)
  );

  rtc_cal_datapath uData (
    .clk(clk), .rstN(rstN), .secTick(secTick), .strobe(strobe),
    .curTime(curTime), .incFlags(incFlags)
  );
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int CLK_PERIOD = 10;
  localparam int SUB_W      = 4;
  localparam int SUBS       = 1 << SUB_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        oscTickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int mSec, mMin, mHour, mMday, mWday, mYday, mMon, mYear, mInc;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar #(.SUB_W(SUB_W)) uut (
    .clk(clk), .rstN(rstN), .oscTickEn(oscTickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic int dim(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int modelField(int idx);
    case (idx)
      0: return mSec;
      1: return mMin;
      2: return mHour;
      3: return mMday;
      4: return mWday;
      5: return mYday;
      6: return mMon;
      default: return mYear;
    endcase
  endfunction

  task automatic modelSecond();
    mSec++; mInc |= 1;
    if (mSec == 60) begin
      mSec = 0; mMin++; mInc |= 2;
      if (mMin == 60) begin
        mMin = 0; mHour++; mInc |= 4;
        if (mHour == 24) begin
          mHour = 0; mInc |= 8 | 16 | 32;
          mWday = (mWday == 6) ? 0 : mWday + 1;
          mYday++; mMday++;
          if (mMday > dim(mMon, mYear)) begin
            mMday = 1; mMon++; mInc |= 64;
            if (mMon > 12) begin
              mMon = 1; mYear++; mYday = 1; mInc |= 128;
            end
          end
        end
      end
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rdAddr = 4'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      oscTickEn = 1'b1;
      @(negedge clk);
      oscTickEn = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic compareAll(input string req);
    int v;
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      chk(req, $sformatf("field%0d", i), v, modelField(i));
    end
  endtask

  task automatic setTime(int yr, int mo, int d, int h, int mi, int s, int wd, int yd);
    wr(8, 32'd2);
    wr(0, 32'(s));  wr(1, 32'(mi)); wr(2, 32'(h));  wr(3, 32'(d));
    wr(4, 32'(wd)); wr(5, 32'(yd)); wr(6, 32'(mo)); wr(7, 32'(yr));
    mSec = s; mMin = mi; mHour = h; mMday = d; mWday = wd; mYday = yd; mMon = mo; mYear = yr;
  endtask

  task automatic runCase(string req, int yr, int mo, int d, int h, int mi, int s,
                         int wd, int yd, int nsec, int mask);
    int v;
    setTime(yr, mo, d, h, mi, s, wd, yd);
    wr(10, 32'(mask));
    wr(12, 32'd3);
    mInc = 0;
    wr(8, 32'd3);
    pulses(nsec * SUBS);
    for (int k = 0; k < nsec; k++) modelSecond();
    wr(8, 32'd2);
    compareAll(req);
    rd(12, v);
    // R10: status bit 0 follows the masked increment flags
    chk("R10", "incStatus", v & 1, ((mInc & mask) != 0) ? 1 : 0);
  endtask

  task automatic secGap(output int gap);
    int prev, cur;
    gap = 0;
    rd(0, prev);
    cur = prev;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk); #1; cur = int'(rdData);
      if (cur != prev) break;
    end
    prev = cur;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk); gap++; #1; cur = int'(rdData);
      if (cur != prev) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, g;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    mYear = 2000; mMon = 1; mMday = 1; mHour = 0; mMin = 0; mSec = 0; mWday = 6; mYday = 1;
    compareAll("R1");
    rd(8, v);  chk("R1", "ctrl", v, 0);
    rd(12, v); chk("R1", "status", v, 0);
    rd(14, v); chk("R1", "unused", v, 0);
    chk("R1", "irq", int'(irq), 0);

    // R9: disabled counter ignores pulses, field writes raise nothing
    wr(10, 32'hFF); wr(12, 32'd3);
    wr(8, 32'd2);
    wr(0, 32'd5);
    pulses(2 * SUBS);
    rd(0, v);  chk("R9", "secHeld", v, 5);
    rd(12, v); chk("R9", "noStatus", v, 0);
    chk("R9", "irqLow", int'(irq), 0);

    // R7: one second per 2^SUB_W oscillator pulses
    setTime(2021, 6, 10, 8, 30, 0, 3, 161);
    wr(10, 32'd0);
    wr(8, 32'd3);
    pulses(SUBS - 1);
    rd(0, v); chk("R7", "beforeSecond", v, 0);
    repeat (5) @(negedge clk);
    pulses(1);
    rd(0, v); chk("R7", "afterSecond", v, 1);

    // R13: disabling restarts the sub-second phase
    wr(8, 32'd2); wr(8, 32'd3);
    pulses(SUBS / 2);
    wr(8, 32'd2); wr(8, 32'd3);
    pulses(SUBS / 2);
    rd(0, v); chk("R13", "phaseCleared", v, 1);
    pulses(SUBS / 2);
    rd(0, v); chk("R13", "fullSecond", v, 2);
    wr(8, 32'd2);

    // directed calendar corners
    runCase("R2", 2021, 6, 10, 13, 59, 59, 3, 161, 1, 4);
    runCase("R3", 2024, 2, 28, 23, 59, 59, 3, 59, 1, 8);
    runCase("R3", 2024, 2, 29, 23, 59, 59, 4, 60, 1, 64);
    runCase("R3", 2023, 2, 28, 23, 59, 59, 2, 59, 1, 64);
    runCase("R3", 2023, 4, 30, 23, 59, 59, 0, 120, 1, 0);
    runCase("R4", 2023, 12, 31, 23, 59, 59, 0, 365, 1, 128);
    runCase("R5", 2022, 7, 9, 23, 59, 59, 6, 190, 1, 16);
    runCase("R6", 2024, 12, 30, 23, 59, 59, 1, 365, 1, 32);
    runCase("R6", 2099, 12, 31, 23, 59, 58, 4, 365, 2, 1);

    // R11: fractional interrupts at 2 and 4 sub-ticks
    setTime(2021, 1, 1, 0, 0, 0, 5, 1);
    wr(10, 32'd0); wr(11, 32'd1); wr(12, 32'd3);
    wr(8, 32'd3);
    pulses(1);
    rd(12, v); chk("R11", "half1", v, 0);
    pulses(1);
    rd(12, v); chk("R11", "half2", v, 2);
    wr(8, 32'd2); wr(11, 32'd2); wr(12, 32'd3); wr(8, 32'd3);
    pulses(3);
    rd(12, v); chk("R11", "quarter3", v, 0);
    pulses(1);
    rd(12, v); chk("R11", "quarter4", v, 2);
    chk("R12", "irqHigh", int'(irq), 1);
    wr(8, 32'd2);
    // R12: write-one-to-clear per bit
    wr(12, 32'd1);
    rd(12, v); chk("R12", "keepBit1", v, 2);
    wr(12, 32'd2);
    rd(12, v); chk("R12", "cleared", v, 0);
    chk("R12", "irqLow", int'(irq), 0);
    wr(11, 32'd0);

    // R8: prescaler timing
    setTime(2021, 1, 1, 0, 0, 0, 5, 1);
    wr(9, 32'h0000_0002);
    wr(8, 32'd1);
    secGap(g); chk("R8", "intGap", g, 48);
    secGap(g); chk("R8", "intGap2", g, 48);
    wr(8, 32'd0);
    wr(9, 32'h8000_0002);
    wr(8, 32'd1);
    secGap(g); chk("R8", "fracGap", g, 56);
    secGap(g); chk("R8", "fracGap2", g, 56);
    wr(8, 32'd0);

    // random boundary-biased cases (R2..R6, R10)
    for (int it = 0; it < 24; it++) begin
      int yr, mo, d, h, mi, s, wd, yd;
      yr = 1901 + int'($urandom_range(0, 198));
      mo = int'($urandom_range(1, 12));
      d  = dim(mo, yr) - int'($urandom_range(0, 1));
      h  = ($urandom_range(0, 2) != 0) ? 23 : int'($urandom_range(0, 23));
      mi = ($urandom_range(0, 2) != 0) ? 59 : int'($urandom_range(0, 59));
      s  = 57 + int'($urandom_range(0, 2));
      wd = int'($urandom_range(0, 6));
      yd = int'($urandom_range(1, 360));
      runCase("R2", yr, mo, d, h, mi, s, wd, yd, int'($urandom_range(1, 3)),
              int'($urandom_range(0, 255)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule